// File: doc/BRIEF.md
# Receive/Transmit FIFO Threshold Interrupt Controller

This block sits beside a pair of byte FIFOs and turns their occupancy into interrupt conditions for a host. It watches the receive FIFO fill level and push events, and compares the fill level with a programmable threshold. It records five receive-side conditions as sticky flags. A host reaches the block over a small register bus to program thresholds, choose which flags may interrupt, clear flags and read both FIFO fill levels.

The interrupt request is active high. It is asserted whenever at least one flag is both set and enabled. A flag whose condition still holds cannot be cleared: a clear written in the same cycle as a new set event loses to the set, so no event is missed.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Address 0 holds the thresholds, written and read back as a 12-bit word. Bits [5:0] are the receive threshold and bits [11:6] are the transmit threshold. Both reset to 0.
- R2: Address 2 is the enable mask. It stores bits [4:0] of a write, and reads return 0 in bits [11:5]. It resets to 0.
- R3: Address 4 is read-only. It returns the receive fill level in bits [11:6] and the transmit fill level in bits [5:0].
- R4: Address 1 returns the status flags with this bit map: bit 0 receive level below threshold, bit 1 receive FIFO empty, bit 2 receive level above threshold, bit 3 receive overflow, bit 4 receive FIFO not empty. A flag is set at the first clock edge at which its condition holds, and it reads as set from the following cycle.
- R5: A status flag stays set after its condition goes away, until it is cleared.
- R6: The overflow flag is set by a push while the receive fill level equals the FIFO depth (32). A push at any lower level leaves the flag unchanged.
- R7: A write to address 3 clears each status flag whose bit is 1 in the written data. Bits written as 0 leave their flags unchanged, and reads of address 3 return 0.
- R8: When a flag's set condition and a clear of that flag fall in the same cycle, the flag stays set.
- R9: The interrupt output is high exactly when some status flag and its enable bit are both 1. It follows the registers with no extra delay.
- R10: While reset is held, the status, enable and threshold registers read 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data for reg_addr, combinational |
| rx_level | input | 6 | Receive FIFO fill level, 0 to 32 |
| tx_level | input | 6 | Transmit FIFO fill level, 0 to 32 |
| rx_push | input | 1 | Receive FIFO push attempt this cycle |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two events can land on the same flag in one clock: a host write to the clear register, and the condition that sets that flag. The bench provokes this in two ways. It writes a clear of the not-empty flag while the receive level is nonzero, and it clears all flags at once while several conditions still hold. In both cases it reads the status register on the next cycle and expects the live conditions to remain set. A second case clears only a flag whose condition has gone away. There the bench expects that flag to drop and every other bit to stay as it was.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
    localparam int ADDR_W = 3;
    localparam int NFLAG  = 5;

    localparam logic [ADDR_W-1:0] A_THR  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

    // flag bit positions (host software decodes these)
    localparam int F_UNDER = 0;
    localparam int F_EMPTY = 1;
    localparam int F_OVER  = 2;
    localparam int F_OVF   = 3;
    localparam int F_NEMP  = 4;
endpackage

// File: rtl/fifo_irq_cond.sv
module fifo_irq_cond
    import fifo_irq_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int DEPTH = 32
) (
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] rx_thr,
    input  logic             rx_push,
    output logic [NFLAG-1:0] cond
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    always_comb begin
        cond          = '0;
        cond[F_UNDER] = rx_level < rx_thr;
        cond[F_EMPTY] = rx_level == '0;
        cond[F_OVER]  = rx_level > rx_thr;
        cond[F_OVF]   = rx_push && (rx_level >= FULL);
        cond[F_NEMP]  = rx_level != '0;
    end
endmodule

// File: rtl/fifo_irq_regs.sv
module fifo_irq_regs
    import fifo_irq_pkg::*;
#(
    parameter int CNT_W = 6,
    localparam int REG_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NFLAG-1:0]  cond,
    output logic [REG_W-1:0]  thr_q,
    output logic [NFLAG-1:0]  en_q,
    output logic [NFLAG-1:0]  stat_q
);
    typedef struct packed {
        logic [REG_W-1:0] thr;
        logic [NFLAG-1:0] en;
        logic [NFLAG-1:0] stat;
    } regs_t;

    regs_t            r_d, r_q;
    logic [NFLAG-1:0] clr_d;

    always_comb begin
        r_d   = r_q;
        clr_d = '0;
        if (wr && addr == A_THR) r_d.thr = wdata;
        if (wr && addr == A_EN)  r_d.en  = wdata[NFLAG-1:0];
        if (wr && addr == A_CLR) clr_d   = wdata[NFLAG-1:0];
        // set beats clear: OR after masking
        r_d.stat = (r_q.stat & ~clr_d) | cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign thr_q  = r_q.thr;
    assign en_q   = r_q.en;
    assign stat_q = r_q.stat;
endmodule

// File: rtl/fifo_irq_rdmux.sv
module fifo_irq_rdmux
    import fifo_irq_pkg::*;
#(
    parameter int CNT_W = 6,
    localparam int REG_W = 2 * CNT_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  thr,
    input  logic [NFLAG-1:0]  en,
    input  logic [NFLAG-1:0]  stat,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_level,
    output logic [REG_W-1:0]  rdata
);
    always_comb begin
        case (addr)
            A_THR:   rdata = thr;
            A_STAT:  rdata = REG_W'(stat);
            A_EN:    rdata = REG_W'(en);
            A_CNT:   rdata = {rx_level, tx_level};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int DEPTH = 32,
    localparam int REG_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic              rx_push,
    output logic              irq
);
    logic [NFLAG-1:0] cond;
    logic [REG_W-1:0] thr_q;
    logic [NFLAG-1:0] en_q;
    logic [NFLAG-1:0] stat_q;

    fifo_irq_cond #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_cond (
        .rx_level (rx_level),
        .rx_thr   (thr_q[CNT_W-1:0]),
        .rx_push  (rx_push),
        .cond     (cond)
    );

    fifo_irq_regs #(.CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .cond   (cond),
        .thr_q  (thr_q),
        .en_q   (en_q),
        .stat_q (stat_q)
    );

    fifo_irq_rdmux #(.CNT_W(CNT_W)) u_rd (
        .addr     (reg_addr),
        .thr      (thr_q),
        .en       (en_q),
        .stat     (stat_q),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rdata    (reg_rdata)
    );

    assign irq = |(stat_q & en_q);
endmodule

// File: rtl/fifo_irq_chk.sv
module fifo_irq_chk
    import fifo_irq_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int DEPTH = 32,
    localparam int REG_W = 2 * CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [CNT_W-1:0]  rx_level,
    input logic              rx_push,
    input logic              irq,
    input logic [NFLAG-1:0]  stat,
    input logic [NFLAG-1:0]  en
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic clr_wr;
    assign clr_wr = wr && addr == A_CLR;

    AST_EMPTY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level == '0 |=> stat[F_EMPTY]); // R4

    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_level == FULL |=> stat[F_OVF]); // R6

    AST_NO_FALSE_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[F_OVF] && !(rx_push && rx_level >= FULL) |=> !stat[F_OVF]); // R6

    for (genvar i = 0; i < NFLAG; i++) begin : g_sticky
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            stat[i] && !(clr_wr && wdata[i]) |=> stat[i]); // R5
    end

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && wdata[F_NEMP] && rx_level == '0 |=> !stat[F_NEMP]); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && wdata[F_EMPTY] && rx_level == '0 |=> stat[F_EMPTY]); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        en == '0 |-> !irq); // R9
endmodule

bind fifo_irq_ctrl fifo_irq_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rx_level (rx_level),
    .rx_push  (rx_push),
    .irq      (irq),
    .stat     (stat_q),
    .en       (en_q)
);

// File: tb/sim_fifo_irq_ctrl.sv
module sim_fifo_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // {rx[29:24], tx[23:18], rx_thr[17:12], tx_thr[11:6], push[5], expected status[4:0]}
    localparam logic [29:0] VEC [NV] = '{
        {6'd0,  6'd0,  6'd0,  6'd0,  1'b0, 5'h02},
        {6'd0,  6'd5,  6'd4,  6'd7,  1'b0, 5'h03},
        {6'd5,  6'd0,  6'd5,  6'd1,  1'b0, 5'h10},
        {6'd10, 6'd3,  6'd4,  6'd2,  1'b0, 5'h14},
        {6'd3,  6'd7,  6'd9,  6'd9,  1'b0, 5'h11},
        {6'd32, 6'd1,  6'd31, 6'd0,  1'b1, 5'h1C},
        {6'd31, 6'd0,  6'd31, 6'd5,  1'b1, 5'h10},
        {6'd32, 6'd2,  6'd32, 6'd3,  1'b0, 5'h10},
        {6'd0,  6'd9,  6'd63, 6'd63, 1'b0, 5'h03},
        {6'd20, 6'd20, 6'd0,  6'd20, 1'b0, 5'h14}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 0;
    logic [11:0] reg_wdata = '0;
    logic [11:0] reg_rdata;
    logic [5:0]  rx_level = '0;
    logic [5:0]  tx_level = '0;
    logic        rx_push = 0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [11:0] rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fifo_irq_ctrl u0 (
        .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
        .rx_level, .tx_level, .rx_push, .irq
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R10: reset state
        #(CLK_PERIOD * 2 + 2);
        rd(3'd1, rv); check("R10 status", rv, 12'h000);
        rd(3'd2, rv); check("R10 enable", rv, 12'h000);
        rd(3'd0, rv); check("R10 thresholds", rv, 12'h000);
        check("R10 irq", {11'd0, irq}, 12'h000);
        @(negedge clk); rst_n = 1;

        // table walk: R1, R3, R4, R6
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            rx_level = v[29:24];
            tx_level = v[23:18];
            wr(3'd0, {v[11:6], v[17:12]});
            wr(3'd3, 12'h01F);
            rx_push = v[5];
            @(negedge clk);
            rx_push = 0;
            rd(3'd1, rv); check($sformatf("R4/R6 status vec %0d", i), rv, {7'd0, v[4:0]});
            rd(3'd4, rv); check($sformatf("R3 levels vec %0d", i), rv, {v[29:24], v[23:18]});
            rd(3'd0, rv); check($sformatf("R1 thresholds vec %0d", i), rv, {v[11:6], v[17:12]});
        end

        // R5: sticky empty flag after level rises
        rx_level = 6'd0;
        wr(3'd0, 12'h000);
        wr(3'd3, 12'h01F);
        rd(3'd1, rv); check("R4 empty only", rv, 12'h002);
        rx_level = 6'd5;
        @(negedge clk);
        rd(3'd1, rv); check("R5 empty stays set", rv, 12'h016);

        // R7: partial clear, zero clear, read of clear register
        wr(3'd3, 12'h002);
        rd(3'd1, rv); check("R7 clear one bit", rv, 12'h014);
        wr(3'd3, 12'h000);
        rd(3'd1, rv); check("R7 zero write no effect", rv, 12'h014);
        rd(3'd3, rv); check("R7 clear reads zero", rv, 12'h000);

        // R8: clear while condition holds
        wr(3'd3, 12'h010);
        rd(3'd1, rv); check("R8 set beats clear", rv, 12'h014);

        // R9: masking
        wr(3'd2, 12'h002);
        check("R9 masked irq low", {11'd0, irq}, 12'h000);
        wr(3'd2, 12'h004);
        check("R9 enabled irq high", {11'd0, irq}, 12'h001);
        wr(3'd2, 12'h008);
        check("R9 overflow not yet set", {11'd0, irq}, 12'h000);

        // R6 + R9: overflow push raises irq
        rx_level = 6'd32;
        rx_push = 1;
        @(negedge clk);
        rx_push = 0;
        #1;
        check("R6/R9 overflow irq", {11'd0, irq}, 12'h001);

        // R2: enable readback width
        wr(3'd2, 12'hFFF);
        rd(3'd2, rv); check("R2 enable readback", rv, 12'h01F);

        // R1: full threshold word
        wr(3'd0, 12'hA53);
        rd(3'd0, rv); check("R1 threshold word", rv, 12'hA53);

        summary();
    end
endmodule